// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out the next program counter for a small 32-bit RISC core. Each cycle it takes the current PC, the fetched instruction word and the values read for the instruction's two register fields. It then resolves one of four conditional branches or the jump-and-link. Conditional branches compare the two register values. A taken branch jumps to an absolute address, which is the 17-bit immediate times four. A not-taken branch falls through to PC+4. Jump-and-link takes its target from the second register operand and returns PC+4 as a link value for the register named by the first field.

All results are registered, so they appear one clock after the inputs are presented. Instruction fetch, pipeline flushing, exceptions and the register file itself sit outside the block. The fields it decodes are fixed: opcode in bits 31..27, first register field in bits 26..22, second register field in bits 21..17, immediate in bits 16..0.

Top module: `bju_nextpc`

## Requirements
- R1: Opcode 11000 (branch-if-equal) is taken when the two effective operands are equal. When taken, next PC = zero-extended immediate shifted left by 2.
- R2: Opcode 11001 (branch-if-not-equal) is taken when the two effective operands differ, with the same target as R1.
- R3: Opcode 11010 (branch-if-less) is taken when the first operand is less than the second as signed two's-complement values.
- R4: Opcode 11011 (branch-if-less-or-equal) is taken when the first operand is signed-less-than or equal to the second.
- R5: Whenever taken is low, next PC equals the presented PC plus 4, wrapping modulo 2^32.
- R6: Opcode 11100 (jump-and-link) is always taken. Next PC equals the second effective operand. The link value equals PC+4. The link enable is high.
- R7: A register field of 00000 makes its operand read as zero, whatever the operand input carries. A jump-and-link whose first field is 00000 keeps the link enable low.
- R8: Any opcode other than the five above gives next PC = PC+4, taken low and link enable low. This includes unused codes in row 11.
- R9: Outputs update one clock after the inputs are sampled. While reset is active, next PC is 0 and taken and link enable are low.
- R10: The immediate is never sign-extended. An immediate of 0x1FFFF gives a target of 0x0007FFFC, and branch targets always have bits 1..0 and 31..19 at zero.
- R11: The link index output carries the first register field (bits 26..22) of the sampled instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | PC of the instruction presented |
| instr_i | input | 32 | Instruction word |
| opa_val_i | input | 32 | Value read for register field bits 26..22 |
| opb_val_i | input | 32 | Value read for register field bits 21..17 |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Control flow left the sequential path |
| link_we_o | output | 1 | Write enable for the link register |
| link_idx_o | output | 5 | Register index to receive the link value |
| link_val_o | output | 32 | Return address (PC+4) |

## Verification
A wrong compare result or decode shows at the ports in the very next cycle. The taken flag and next PC then disagree with the computed outcome, for example a fall-through where an absolute target was due. A fault in the zero-register handling shows up only when a field is 00000 while its operand input is nonzero. A sign-handling fault shows only for operand pairs of mixed sign, or for immediates with bit 16 set. Back-to-back instructions of differing kinds expose any state carried between samples, because each result must depend only on the preceding cycle's inputs.

// File: rtl/bju_pkg.sv
package bju_pkg;
   localparam int OP_W = 5;

   typedef enum logic [2:0] {
      FK_SEQ,
      FK_BEQ,
      FK_BNE,
      FK_BLT,
      FK_BLE,
      FK_JAL
   } flow_kind_e;

   localparam logic [OP_W-1:0] OPC_BEQ = 5'b11000;
   localparam logic [OP_W-1:0] OPC_BNE = 5'b11001;
   localparam logic [OP_W-1:0] OPC_BLT = 5'b11010;
   localparam logic [OP_W-1:0] OPC_BLE = 5'b11011;
   localparam logic [OP_W-1:0] OPC_JAL = 5'b11100;
endpackage

// File: rtl/bju_decode.sv
module bju_decode
   import bju_pkg::*;
(
   input  logic [OP_W-1:0] opcode_i,
   output flow_kind_e      kind_o
);
   always_comb begin
      case (opcode_i)
         OPC_BEQ: kind_o = FK_BEQ;
         OPC_BNE: kind_o = FK_BNE;
         OPC_BLT: kind_o = FK_BLT;
         OPC_BLE: kind_o = FK_BLE;
         OPC_JAL: kind_o = FK_JAL;
         default: kind_o = FK_SEQ;
      endcase
   end
endmodule

// File: rtl/bju_compare.sv
module bju_compare #(
   parameter int W          = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [W-1:0] lhs_i,
   input  logic [W-1:0] rhs_i,
   output logic         eq_o,
   output logic         lt_o
);
   if (W < 2) begin : g_bad_w
      $error("bju_compare: W must be at least 2");
   end

   assign eq_o = (lhs_i == rhs_i);

   if (SIGNED_CMP) begin : g_signed
      assign lt_o = ($signed(lhs_i) < $signed(rhs_i));
   end else begin : g_unsigned
      assign lt_o = (lhs_i < rhs_i);
   end
endmodule

// File: rtl/bju_target.sv
module bju_target #(
   parameter int XLEN    = 32,
   parameter int IMM_W   = 17,
   parameter int SCALE_SH = 2,
   parameter int STEP    = 4
) (
   input  logic [XLEN-1:0]  pc_i,
   input  logic [IMM_W-1:0] imm_i,
   output logic [XLEN-1:0]  seq_pc_o,
   output logic [XLEN-1:0]  abs_tgt_o
);
   localparam int PAD_W = XLEN - IMM_W - SCALE_SH;

   if (PAD_W < 0) begin : g_bad_fit
      $error("bju_target: scaled immediate does not fit XLEN");
   end

   assign seq_pc_o = pc_i + XLEN'(STEP);

   if (PAD_W == 0) begin : g_nopad
      assign abs_tgt_o = {imm_i, {SCALE_SH{1'b0}}};
   end else begin : g_pad
      assign abs_tgt_o = {{PAD_W{1'b0}}, imm_i, {SCALE_SH{1'b0}}};
   end
endmodule

// File: rtl/bju_nextpc.sv
module bju_nextpc
   import bju_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int RIDX_W        = 5,
   parameter int IMM_W         = 17,
   parameter int SCALE_SH      = 2,
   parameter int STEP          = 4,
   parameter bit SIGNED_CMP    = 1'b1,
   parameter bit HARDWIRED_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   instr_i,
   input  logic [XLEN-1:0]   opa_val_i,
   input  logic [XLEN-1:0]   opb_val_i,
   output logic [XLEN-1:0]   npc_o,
   output logic              taken_o,
   output logic              link_we_o,
   output logic [RIDX_W-1:0] link_idx_o,
   output logic [XLEN-1:0]   link_val_o
);
   localparam int OP_LSB = XLEN - OP_W;
   localparam int A_LSB  = OP_LSB - RIDX_W;
   localparam int B_LSB  = A_LSB - RIDX_W;

   if (B_LSB < IMM_W) begin : g_bad_fields
      $error("bju_nextpc: immediate overlaps register fields");
   end

   logic [OP_W-1:0]   opcode;
   logic [RIDX_W-1:0] a_idx, b_idx;
   logic [IMM_W-1:0]  imm;
   logic [XLEN-1:0]   a_eff, b_eff;
   logic [XLEN-1:0]   seq_pc, abs_tgt;
   logic              cmp_eq, cmp_lt;
   flow_kind_e        kind;

   assign opcode = instr_i[XLEN-1:OP_LSB];
   assign a_idx  = instr_i[OP_LSB-1:A_LSB];
   assign b_idx  = instr_i[A_LSB-1:B_LSB];
   assign imm    = instr_i[IMM_W-1:0];

   if (HARDWIRED_ZERO) begin : g_zero_reg
      assign a_eff = (a_idx == '0) ? '0 : opa_val_i;
      assign b_eff = (b_idx == '0) ? '0 : opb_val_i;
   end else begin : g_plain_reg
      assign a_eff = opa_val_i;
      assign b_eff = opb_val_i;
   end

   bju_decode u_dec (
      .opcode_i (opcode),
      .kind_o   (kind)
   );

   bju_compare #(.W(XLEN), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .lhs_i (a_eff),
      .rhs_i (b_eff),
      .eq_o  (cmp_eq),
      .lt_o  (cmp_lt)
   );

   bju_target #(.XLEN(XLEN), .IMM_W(IMM_W), .SCALE_SH(SCALE_SH), .STEP(STEP)) u_tgt (
      .pc_i      (pc_i),
      .imm_i     (imm),
      .seq_pc_o  (seq_pc),
      .abs_tgt_o (abs_tgt)
   );

   logic            take_c, we_c;
   logic [XLEN-1:0] npc_c;

   always_comb begin
      case (kind)
         FK_BEQ:  take_c = cmp_eq;
         FK_BNE:  take_c = !cmp_eq;
         FK_BLT:  take_c = cmp_lt;
         FK_BLE:  take_c = cmp_lt || cmp_eq;
         FK_JAL:  take_c = 1'b1;
         default: take_c = 1'b0;
      endcase
      if (kind == FK_JAL)  npc_c = b_eff;
      else if (take_c)     npc_c = abs_tgt;
      else                 npc_c = seq_pc;
      we_c = (kind == FK_JAL) && (!HARDWIRED_ZERO || a_idx != '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         npc_o      <= '0;
         taken_o    <= 1'b0;
         link_we_o  <= 1'b0;
         link_idx_o <= '0;
         link_val_o <= '0;
      end else begin
         npc_o      <= npc_c;
         taken_o    <= take_c;
         link_we_o  <= we_c;
         link_idx_o <= a_idx;
         link_val_o <= seq_pc;
      end
   end

   // marks that outputs reflect a sample taken out of reset
   logic started;
   always_ff @(posedge clk) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !taken_o) |-> (npc_o == $past(pc_i) + XLEN'(STEP)));

   a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
      (started && link_we_o) |-> (link_val_o == $past(pc_i) + XLEN'(STEP) && taken_o));

   a_r7_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      (link_idx_o == '0) |-> !link_we_o);

   a_r8_quiet_rows: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(instr_i[XLEN-1:XLEN-2]) != 2'b11) |-> (!taken_o && !link_we_o));

   a_r10_target_range: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(instr_i[XLEN-1:XLEN-3]) == 3'b110 && taken_o)
         |-> (npc_o[SCALE_SH-1:0] == '0 && npc_o[XLEN-1:IMM_W+SCALE_SH] == '0));

   a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(opcode) == OPC_JAL && $past(a_idx) != '0) |-> link_we_o);
endmodule

// File: tb/bju_nextpc_test.sv
`timescale 1ns/1ps
module bju_nextpc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0, instr_i = '0, opa_val_i = '0, opb_val_i = '0;
   logic [31:0] npc_o, link_val_o;
   logic        taken_o, link_we_o;
   logic [4:0]  link_idx_o;

   always #2 clk = ~clk;

   bju_nextpc uut (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i),
      .opa_val_i(opa_val_i), .opb_val_i(opb_val_i),
      .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
      .link_idx_o(link_idx_o), .link_val_o(link_val_o)
   );

   typedef struct {
      int          due;
      string       tag;
      logic [31:0] npc;
      logic        tk;
      logic        we;
      logic [4:0]  idx;
      logic [31:0] lv;
   } exp_t;

   exp_t q[$];
   int cyc = 0, total = 0, bad = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic send(input logic [31:0] pc, input logic [4:0] op,
                       input logic [4:0] fa, input logic [4:0] fb,
                       input logic [16:0] imm, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
      exp_t e;
      logic [31:0] av, bv, pc4, tgt;
      logic tk;
      @(negedge clk);
      pc_i = pc; instr_i = {op, fa, fb, imm}; opa_val_i = a; opb_val_i = b;
      av  = (fa == 0) ? 32'd0 : a;
      bv  = (fb == 0) ? 32'd0 : b;
      pc4 = pc + 32'd4;
      tgt = {13'd0, imm, 2'b00};
      case (op)
         5'b11000: tk = (av == bv);
         5'b11001: tk = (av != bv);
         5'b11010: tk = ($signed(av) < $signed(bv));
         5'b11011: tk = ($signed(av) <= $signed(bv));
         5'b11100: tk = 1'b1;
         default:  tk = 1'b0;
      endcase
      e.due = cyc + 1; e.tag = tag; e.tk = tk; e.idx = fa; e.lv = pc4;
      e.we  = (op == 5'b11100) && (fa != 0);
      e.npc = (op == 5'b11100) ? bv : (tk ? tgt : pc4);
      q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (npc_o !== e.npc || taken_o !== e.tk || link_we_o !== e.we
             || link_idx_o !== e.idx || (e.we && link_val_o !== e.lv)) begin
            bad++;
            $display("FAIL %s: got npc=%h tk=%b we=%b idx=%0d lv=%h exp npc=%h tk=%b we=%b idx=%0d lv=%h",
                     e.tag, npc_o, taken_o, link_we_o, link_idx_o, link_val_o,
                     e.npc, e.tk, e.we, e.idx, e.lv);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      total++; // R9 reset state
      if (npc_o !== 0 || taken_o !== 0 || link_we_o !== 0) begin
         bad++;
         $display("FAIL R9 reset: got npc=%h tk=%b we=%b exp 0 0 0", npc_o, taken_o, link_we_o);
      end
      rst_n = 1'b1;
      send(32'h100, 5'b11000, 5'd1, 5'd2, 17'h100, 32'd7, 32'd7, "R1 beq equal");
      send(32'h104, 5'b11000, 5'd1, 5'd2, 17'h100, 32'd7, 32'd8, "R1 beq differ");
      send(32'h108, 5'b11001, 5'd3, 5'd4, 17'h020, 32'd1, 32'd2, "R2 bne differ");
      send(32'h10C, 5'b11001, 5'd3, 5'd4, 17'h020, 32'd5, 32'd5, "R2 bne equal");
      send(32'h110, 5'b11010, 5'd5, 5'd6, 17'h040, 32'hFFFFFFFF, 32'd1, "R3 blt signed neg");
      send(32'h114, 5'b11010, 5'd5, 5'd6, 17'h040, 32'd1, 32'hFFFFFFFF, "R3 blt not");
      send(32'h118, 5'b11011, 5'd7, 5'd8, 17'h050, 32'h80000000, 32'h80000000, "R4 ble equal");
      send(32'h11C, 5'b11011, 5'd7, 5'd8, 17'h050, 32'd9, 32'd3, "R4 ble greater");
      send(32'hFFFFFFFC, 5'b11000, 5'd1, 5'd2, 17'h001, 32'd1, 32'd2, "R5 wrap");
      send(32'h200, 5'b11100, 5'd25, 5'd9, 17'h000, 32'd0, 32'h00004444, "R6 jal");
      send(32'h204, 5'b11100, 5'd0, 5'd9, 17'h000, 32'h5, 32'h00008888, "R7 jal zero link");
      send(32'h208, 5'b11000, 5'd0, 5'd3, 17'h010, 32'hDEAD, 32'd0, "R7 zero reads");
      send(32'h20C, 5'b11100, 5'd4, 5'd0, 17'h000, 32'd0, 32'h12345678, "R7 jal zero target");
      send(32'h210, 5'b00001, 5'd1, 5'd2, 17'h010, 32'd1, 32'd1, "R8 alu op");
      send(32'h214, 5'b11101, 5'd1, 5'd2, 17'h010, 32'd1, 32'd1, "R8 unused row11");
      send(32'h218, 5'b11000, 5'd1, 5'd2, 17'h1FFFF, 32'd3, 32'd3, "R10 imm max");
      send(32'h21C, 5'b11001, 5'd31, 5'd30, 17'h10000, 32'd1, 32'd0, "R10 imm bit16");
      send(32'h220, 5'b11011, 5'd17, 5'd18, 17'h003, 32'hFFFFFFF0, 32'hFFFFFFF1, "R11 idx");
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hang exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule